// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block watches the stream of converter results and raises a flag when a result leaves a programmable band. Each result arrives with its channel index and a one-cycle valid strobe. If the watchdog is enabled and the result qualifies, it is compared against a low and a high bound. A result outside the band sets a sticky event flag, which software clears by writing a one.

Qualification has two modes. In the all-channel mode, every result from a channel that the sequence mask has switched on is checked. In the single-channel mode, only results from one selected channel are checked, and only if that channel's bit in the sequence mask is also set. The interrupt line follows the flag, gated by an interrupt-enable input.

Top module: `adc_window_guard`

## Requirements
- R1: After a synchronous active-low reset, `evt_flag` and `evt_irq` are 0.
- R2: `thr_word` carries the low bound in bits [11:0] and the high bound in bits [27:16]. Bits [15:12] and [31:28] have no effect.
- R3: A qualified result strictly above the high bound, or strictly below the low bound, sets `evt_flag` at the clock edge that samples `res_valid`.
- R4: A result equal to the low bound or equal to the high bound lies inside the band and does not set the flag.
- R5: While `wd_en` is 0, the flag is never set, whatever results arrive.
- R6: With `single_mode` at 0, a result on any channel 0..18 whose `seq_mask` bit is 1 is checked.
- R7: With `single_mode` at 1, only results whose `res_chan` equals `guard_chan` are checked. Results on other channels are ignored.
- R8: A result whose channel has its `seq_mask` bit at 0 is ignored in both modes. This includes the guarded channel in the single-channel mode.
- R9: Once set, the flag stays set through later in-window results and through clear writes whose `clr_data` is 0.
- R10: A cycle with `clr_wr`=1 and `clr_data`=1 clears the flag at that edge. This is the write-one-to-clear action.
- R11: If a clear write and a new violation fall on the same edge, the flag ends that edge set.
- R12: `evt_irq` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R13: A result with a channel index of 19 or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a result is present |
| res_data | input | 12 | Conversion result |
| res_chan | input | 5 | Channel index of the result |
| wd_en | input | 1 | Watchdog enable |
| single_mode | input | 1 | 1: guard one channel only |
| guard_chan | input | 5 | Channel guarded in the single-channel mode |
| seq_mask | input | 19 | Channels switched on in the conversion sequence |
| thr_word | input | 32 | Low bound in [11:0], high bound in [27:16] |
| clr_wr | input | 1 | Write strobe to the flag's status bit |
| clr_data | input | 1 | Data written to the flag's status bit (1 clears) |
| irq_en | input | 1 | Interrupt enable |
| evt_flag | output | 1 | Sticky out-of-band flag |
| evt_irq | output | 1 | Interrupt request |

## Verification
The band check is driven with results one code beyond each bound, results exactly on each bound, a mid-band value, a band that has collapsed to a single code, and a band covering the full range. These patterns separate strict from inclusive comparisons and show which bound each compare uses. The qualification path is tested with the guarded channel against a neighbouring channel, with the mask bit set and cleared, with the highest valid index, and with an index past the last channel. Together these show whether the decode, the mask, the mode and the range check are each taken into account. Directed sequences then cover how the flag holds, how it clears, a clear and a violation on the same edge, and the interrupt gate.

// File: rtl/adc_wdg_pkg.sv
// Shared sizes and the band type for the result window watchdog.
package adc_wdg_pkg;
    localparam int RES_W   = 12;   // result and bound width
    localparam int CH_W    = 5;    // channel index width
    localparam int NUM_CH  = 19;   // channels 0..NUM_CH-1
    localparam int WORD_W  = 32;   // packed bound word width
    localparam int LO_LSB  = 0;    // low bound position in the word
    localparam int HI_LSB  = 16;   // high bound position in the word

    typedef struct packed {
        logic [RES_W-1:0] hi;
        logic [RES_W-1:0] lo;
    } band_t;
endpackage

// File: rtl/wdg_chan_qual.sv
// Channel qualifier: decides whether the present result is subject to the
// band check. Assumes res_chan is meaningful only while res_valid is high.
// Indices at or beyond NUM_CH never qualify.
module wdg_chan_qual #(
    parameter int CH_W   = adc_wdg_pkg::CH_W,
    parameter int NUM_CH = adc_wdg_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_chan,
    input  logic              single_mode,
    input  logic [CH_W-1:0]   guard_chan,
    input  logic [NUM_CH-1:0] seq_mask,
    output logic              take
);
    logic [NUM_CH-1:0] lane_hit;

    // One decode lane per channel: index match, mask bit, mode filter.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        always_comb begin
            lane_hit[i] = (res_chan == CH_W'(i)) && seq_mask[i] &&
                          (!single_mode || (guard_chan == CH_W'(i)));
        end
    end

    // Qualify only on a valid strobe.
    always_comb take = res_valid && (|lane_hit);

    assert_single_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && single_mode) |-> (res_chan == guard_chan));
    assert_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (res_chan < CH_W'(NUM_CH)));
endmodule

// File: rtl/wdg_band_cmp.sv
// Band comparator: unpacks the two bounds from the packed word and reports
// whether a result lies strictly outside them. Both bounds are inclusive.
module wdg_band_cmp #(
    parameter int RES_W  = adc_wdg_pkg::RES_W,
    parameter int WORD_W = adc_wdg_pkg::WORD_W,
    parameter int LO_LSB = adc_wdg_pkg::LO_LSB,
    parameter int HI_LSB = adc_wdg_pkg::HI_LSB
) (
    input  logic [RES_W-1:0]  res_data,
    input  logic [WORD_W-1:0] thr_word,
    output logic              outside
);
    import adc_wdg_pkg::*;

    band_t band;
    logic  above;
    logic  below;
    logic  thr_unused_bits;

    // Pick the bound fields out of the word; spare bits are discarded.
    always_comb begin
        band.lo         = thr_word[LO_LSB +: RES_W];
        band.hi         = thr_word[HI_LSB +: RES_W];
        thr_unused_bits = ^{thr_word[WORD_W-1:HI_LSB+RES_W],
                            thr_word[HI_LSB-1:LO_LSB+RES_W]};
    end

    // Strict compares against each bound.
    always_comb begin
        above   = res_data > band.hi;
        below   = res_data < band.lo;
        outside = above || below;
    end
endmodule

// File: rtl/wdg_event_latch.sv
// Sticky event flag with write-one-to-clear and a gated interrupt.
// Assumes a set and a clear on the same edge resolve to set.
module wdg_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_en,
    input  logic hit,
    input  logic clr_wr,
    input  logic clr_data,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic set_req;
    logic clr_req;

    // Request decode for this edge.
    always_comb begin
        set_req = wd_en && hit;
        clr_req = clr_wr && clr_data;
    end

    // Flag register: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // Interrupt gate.
    always_comb irq = flag && irq_en;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(clr_wr && clr_data)) |=> flag);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data && !(wd_en && hit)) |=> !flag);
    assert_collide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data && wd_en && hit) |=> flag);
    assert_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && !flag) |=> !flag);
endmodule

// File: rtl/adc_window_guard.sv
// Result window watchdog top: qualifies each result by channel, checks it
// against the band and records violations in a sticky flag.
module adc_window_guard #(
    parameter int RES_W  = adc_wdg_pkg::RES_W,
    parameter int CH_W   = adc_wdg_pkg::CH_W,
    parameter int NUM_CH = adc_wdg_pkg::NUM_CH,
    parameter int WORD_W = adc_wdg_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic              wd_en,
    input  logic              single_mode,
    input  logic [CH_W-1:0]   guard_chan,
    input  logic [NUM_CH-1:0] seq_mask,
    input  logic [WORD_W-1:0] thr_word,
    input  logic              clr_wr,
    input  logic              clr_data,
    input  logic              irq_en,
    output logic              evt_flag,
    output logic              evt_irq
);
    logic take;
    logic outside;
    logic hit;

    wdg_chan_qual #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_qual (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .single_mode(single_mode), .guard_chan(guard_chan),
        .seq_mask(seq_mask), .take(take)
    );

    wdg_band_cmp #(.RES_W(RES_W), .WORD_W(WORD_W)) u_cmp (
        .res_data(res_data), .thr_word(thr_word), .outside(outside)
    );

    // A violation needs a qualified result outside the band.
    always_comb hit = take && outside;

    wdg_event_latch u_latch (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .hit(hit),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .flag(evt_flag), .irq(evt_irq)
    );

    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_flag && !res_valid) |=> !evt_flag);
    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |-> (evt_flag && irq_en));
endmodule

// File: tb/adc_window_guard_test.sv
`timescale 1ns/1ps
module adc_window_guard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [11:0] res_data;
    logic [4:0]  res_chan;
    logic        wd_en;
    logic        single_mode;
    logic [4:0]  guard_chan;
    logic [18:0] seq_mask;
    logic [31:0] thr_word;
    logic        clr_wr;
    logic        clr_data;
    logic        irq_en;
    logic        evt_flag;
    logic        evt_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_window_guard uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .wd_en(wd_en), .single_mode(single_mode),
        .guard_chan(guard_chan), .seq_mask(seq_mask), .thr_word(thr_word),
        .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
        .evt_flag(evt_flag), .evt_irq(evt_irq)
    );

    typedef struct packed {
        logic        en;
        logic        single;
        logic [4:0]  guard;
        logic [4:0]  chan;
        logic        mbit;
        logic [11:0] data;
        logic [11:0] lo;
        logic [11:0] hi;
        logic        exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 5'd0, 5'd3,  1'b1, 12'd3001, 12'd100, 12'd3000, 1'b1}, // R3 above
        '{1'b1, 1'b0, 5'd0, 5'd3,  1'b1, 12'd99,   12'd100, 12'd3000, 1'b1}, // R3 below
        '{1'b1, 1'b0, 5'd0, 5'd3,  1'b1, 12'd3000, 12'd100, 12'd3000, 1'b0}, // R4 on high
        '{1'b1, 1'b0, 5'd0, 5'd3,  1'b1, 12'd100,  12'd100, 12'd3000, 1'b0}, // R4 on low
        '{1'b1, 1'b0, 5'd0, 5'd3,  1'b1, 12'd2000, 12'd100, 12'd3000, 1'b0}, // R2 mid
        '{1'b0, 1'b0, 5'd0, 5'd3,  1'b1, 12'd4000, 12'd100, 12'd3000, 1'b0}, // R5 off
        '{1'b1, 1'b1, 5'd5, 5'd5,  1'b1, 12'd4095, 12'd100, 12'd3000, 1'b1}, // R7 guarded
        '{1'b1, 1'b1, 5'd5, 5'd6,  1'b1, 12'd4095, 12'd100, 12'd3000, 1'b0}, // R7 other
        '{1'b1, 1'b1, 5'd5, 5'd5,  1'b0, 12'd4095, 12'd100, 12'd3000, 1'b0}, // R8 unmasked guard
        '{1'b1, 1'b0, 5'd0, 5'd7,  1'b0, 12'd0,    12'd100, 12'd3000, 1'b0}, // R8 unmasked
        '{1'b1, 1'b0, 5'd0, 5'd18, 1'b1, 12'd0,    12'd100, 12'd3000, 1'b1}, // R6 top channel
        '{1'b1, 1'b0, 5'd0, 5'd20, 1'b1, 12'd0,    12'd100, 12'd3000, 1'b0}, // R13 past range
        '{1'b1, 1'b0, 5'd0, 5'd1,  1'b1, 12'd500,  12'd500, 12'd500,  1'b0}, // R4 single code
        '{1'b1, 1'b0, 5'd0, 5'd1,  1'b1, 12'd501,  12'd500, 12'd500,  1'b1}, // R3 single code
        '{1'b1, 1'b0, 5'd0, 5'd2,  1'b1, 12'd0,    12'd0,   12'd4095, 1'b0}  // R4 full range
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Spare word bits are filled with ones to show they are ignored (R2).
    function automatic logic [31:0] pack_band(input logic [11:0] lo, input logic [11:0] hi);
        return {4'hF, hi, 4'hF, lo};
    endfunction

    task automatic clear_flag();
        @(negedge clk); clr_wr = 1'b1; clr_data = 1'b1;
        @(negedge clk); clr_wr = 1'b0; clr_data = 1'b0;
    endtask

    task automatic send(input logic [4:0] ch, input logic [11:0] d);
        @(negedge clk); res_valid = 1'b1; res_chan = ch; res_data = d;
        @(negedge clk); res_valid = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; res_valid = 1'b0; res_data = '0; res_chan = '0;
        wd_en = 1'b0; single_mode = 1'b0; guard_chan = '0; seq_mask = '0;
        thr_word = '0; clr_wr = 1'b0; clr_data = 1'b0; irq_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 flag", evt_flag, 1'b0);
        check("R1 irq", evt_irq, 1'b0);
        rst_n = 1'b1;

        // Table walk: clear, apply one result, sample after its edge.
        for (int i = 0; i < NV; i++) begin
            clear_flag();
            wd_en = VEC[i].en; single_mode = VEC[i].single;
            guard_chan = VEC[i].guard;
            seq_mask = VEC[i].mbit ? (19'd1 << VEC[i].chan) : 19'd0;
            thr_word = pack_band(VEC[i].lo, VEC[i].hi);
            send(VEC[i].chan, VEC[i].data);
            check($sformatf("R2/R3/R4/R5/R6/R7/R8/R13 vector %0d", i), evt_flag, VEC[i].exp);
        end

        // Directed: sticky hold (R9).
        clear_flag();
        wd_en = 1'b1; single_mode = 1'b0; seq_mask = '1;
        thr_word = pack_band(12'd100, 12'd3000);
        send(5'd2, 12'd3500);
        check("R9 set", evt_flag, 1'b1);
        send(5'd2, 12'd1000);
        send(5'd4, 12'd1500);
        check("R9 hold in band", evt_flag, 1'b1);
        @(negedge clk); clr_wr = 1'b1; clr_data = 1'b0;
        @(negedge clk); clr_wr = 1'b0;
        check("R9 zero write", evt_flag, 1'b1);

        // Interrupt gate (R12).
        irq_en = 1'b0; #0.1;
        check("R12 gated off", evt_irq, 1'b0);
        irq_en = 1'b1; #0.1;
        check("R12 gated on", evt_irq, 1'b1);

        // Write-one-to-clear (R10).
        clear_flag();
        check("R10 cleared", evt_flag, 1'b0);
        check("R12 irq follows", evt_irq, 1'b0);

        // Clear and violation on the same edge (R11).
        send(5'd1, 12'd4000);
        @(negedge clk);
        clr_wr = 1'b1; clr_data = 1'b1;
        res_valid = 1'b1; res_chan = 5'd1; res_data = 12'd10;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = 1'b0; res_valid = 1'b0;
        check("R11 collide", evt_flag, 1'b1);

        // Enable dropped while flag set: flag stays, no new set after clear (R5).
        wd_en = 1'b0;
        clear_flag();
        send(5'd1, 12'd4095);
        check("R5 disabled", evt_flag, 1'b0);

        // Reset while set (R1).
        wd_en = 1'b1;
        send(5'd1, 12'd4095);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset clears", evt_flag, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule